// File: doc/BRIEF.md
# Debug trigger state sequencer

This block steps an on-chip debug session through a small state machine: a disarmed idle state, three programmable intermediate states, and a final state that marks the trigger point for trace capture. Software arms the session with a write strobe. Four comparator channels then report matches as single-cycle strobes. Each channel has an enable bit and a break bit. A matching channel moves the session to a target state that is chosen per state by a control field. A software trigger jumps directly to the end of the session, and the jump target depends on the selected trace alignment.

A break-enabled channel raises an immediate breakpoint request whenever it matches while the module is armed. If that channel is also the winning trigger, it ends the session: the sequencer spends exactly one cycle in the final state and then drops back to idle and disarms. The outputs are the registered state flags, the armed status, a trace-trigger pulse, a breakpoint-request pulse, a disarm pulse and a session-complete pulse.

Top module: `dbg_seq_top`

## Requirements
- R1: A synchronous active-high `rst` sets `state_flags` to 000 and `armed` to 0. It also sets `trace_trig`, `brk_req`, `disarm` and `session_done` to 0.
- R2: While disarmed, an `arm_wr` strobe with `arm_wdata`=1 sets `armed` and moves `state_flags` to 001 on the next cycle.
- R3: The state flags are encoded as 000 for idle, 001/010/011 for states 1 to 3, and 100 for final. In state n (1..3), a winning channel that has no break bit moves the sequencer to the target given by `tgt_sel[2n-1:2n-2]`. Field value 00 selects final, and values 01..11 select states 1..3.
- R4: In one cycle only the highest-priority trigger is acted on. The order, highest first, is `sw_trig`, channel 0, channel 1, channel 2, channel 3.
- R5: In states 1..3, `sw_trig` with `trace_mode` 01 (begin) or 10 (mid) moves the sequencer to final. With `trace_mode` 00 (off) or 11 (end), it moves the sequencer to idle and disarms.
- R6: Final always exits to idle on the next cycle. When no arm clear is written in that cycle, the exit raises a one-cycle `session_done` pulse. `disarm` pulses for one cycle on every armed-to-disarmed change.
- R7: While armed, in any state, a match on a channel whose `ch_brk` bit is set raises `brk_req` for one cycle on the next cycle.
- R8: When the winning channel has its `ch_brk` bit set, the sequencer enters final for exactly one cycle and then goes to idle, disarmed. This happens whatever value `tgt_sel` and `trace_mode` hold.
- R9: An `arm_wr` strobe with `arm_wdata`=0 returns the sequencer to idle and disarms it from any state, including final. It overrides every trigger in the same cycle and gives no `session_done`.
- R10: While disarmed, matches and `sw_trig` have no effect and give no `brk_req`. An `arm_wr` of 1 while armed also has no effect.
- R11: `trace_trig` pulses for one cycle, in the same cycle that `state_flags` first shows 100.
- R12: A channel whose `ch_en` and `ch_brk` bits are both clear is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_wr | input | 1 | Write strobe for the arm bit |
| arm_wdata | input | 1 | Arm bit value written with `arm_wr` |
| sw_trig | input | 1 | Software trigger strobe |
| trace_mode | input | 2 | Trace alignment: 00 off, 01 begin, 10 mid, 11 end |
| ch_en | input | NCH | Per-channel sequencer enable |
| ch_brk | input | NCH | Per-channel immediate break enable |
| tgt_sel | input | 6 | Target fields for states 1..3, two bits each |
| match | input | NCH | Per-cycle comparator match strobes |
| state_flags | output | 3 | Current sequencer state |
| armed | output | 1 | Module armed |
| trace_trig | output | 1 | Pulse on entry to final |
| brk_req | output | 1 | Immediate breakpoint request pulse |
| disarm | output | 1 | Pulse when the module disarms |
| session_done | output | 1 | Pulse on the exit from final to idle |

## Verification
Two events can fall in the same cycle: a session-ending trigger and an immediate breakpoint request. The bench provokes this in two ways. It raises a software trigger while a break-enabled channel matches, and it sweeps every match pattern against every enable and break mask from each of the three programmable states. For each case the bench computes the winning trigger, the expected next state and the expected break request on its own. It then judges the two effects separately: the state must follow only the winner, and the breakpoint request must follow every matched break channel.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

  localparam int FLAG_W = 3;
  localparam int SEL_W  = 2;
  localparam int NPROG  = 3;

  typedef enum logic [FLAG_W-1:0] {
    ST_IDLE  = 3'd0,
    ST_ONE   = 3'd1,
    ST_TWO   = 3'd2,
    ST_THREE = 3'd3,
    ST_FINAL = 3'd4
  } seq_state_t;

  typedef enum logic [1:0] {
    TR_OFF   = 2'd0,
    TR_BEGIN = 2'd1,
    TR_MID   = 2'd2,
    TR_END   = 2'd3
  } trace_mode_t;

endpackage

// File: rtl/dbg_seq_arb.sv
module dbg_seq_arb #(
  parameter int NCH = 4,
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0]   match,
  input  logic [NCH-1:0]   qual,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx
);

  logic [NCH-1:0] live;
  assign live = match & qual;

  // lowest channel index wins: scan downwards so the last write is the winner
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (live[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/dbg_seq_next.sv
module dbg_seq_next
  import dbg_seq_pkg::*;
#(
  parameter int NCH = 4
) (
  input  seq_state_t                 cur,
  input  logic                       armed_q,
  input  logic                       arm_wr,
  input  logic                       arm_wdata,
  input  logic                       sw_trig,
  input  logic [1:0]                 trace_mode,
  input  logic                       hit,
  input  logic                       hit_brk,
  input  logic [NPROG*SEL_W-1:0]     tgt_sel,
  output seq_state_t                 nxt,
  output logic                       nxt_armed
);

  logic             clr_req;
  logic [SEL_W-1:0] field;
  seq_state_t       prog_tgt;
  logic             sw_to_final;

  assign clr_req = arm_wr & ~arm_wdata;

  always_comb begin
    unique case (cur)
      ST_ONE:   field = tgt_sel[0*SEL_W +: SEL_W];
      ST_TWO:   field = tgt_sel[1*SEL_W +: SEL_W];
      ST_THREE: field = tgt_sel[2*SEL_W +: SEL_W];
      default:  field = '0;
    endcase
  end

  assign prog_tgt = (field == '0) ? ST_FINAL : seq_state_t'({1'b0, field});

  assign sw_to_final = (trace_mode == TR_BEGIN) || (trace_mode == TR_MID);

  always_comb begin
    nxt       = cur;
    nxt_armed = armed_q;
    if (clr_req) begin
      nxt       = ST_IDLE;
      nxt_armed = 1'b0;
    end else begin
      unique case (cur)
        ST_IDLE: begin
          if (!armed_q && arm_wr && arm_wdata) begin
            nxt       = ST_ONE;
            nxt_armed = 1'b1;
          end
        end
        ST_FINAL: begin
          nxt       = ST_IDLE;
          nxt_armed = 1'b0;
        end
        default: begin
          if (sw_trig) begin
            if (sw_to_final) begin
              nxt = ST_FINAL;
            end else begin
              nxt       = ST_IDLE;
              nxt_armed = 1'b0;
            end
          end else if (hit) begin
            nxt = hit_brk ? ST_FINAL : prog_tgt;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/dbg_seq_top.sv
module dbg_seq_top
  import dbg_seq_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   arm_wr,
  input  logic                   arm_wdata,
  input  logic                   sw_trig,
  input  logic [1:0]             trace_mode,
  input  logic [NCH-1:0]         ch_en,
  input  logic [NCH-1:0]         ch_brk,
  input  logic [NPROG*SEL_W-1:0] tgt_sel,
  input  logic [NCH-1:0]         match,
  output logic [FLAG_W-1:0]      state_flags,
  output logic                   armed,
  output logic                   trace_trig,
  output logic                   brk_req,
  output logic                   disarm,
  output logic                   session_done
);

  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

  seq_state_t       cur_q, nxt;
  logic             armed_q, nxt_armed;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic             brk_any;
  logic             clr_req;

  dbg_seq_arb #(.NCH(NCH)) u_arb (
    .match   (match),
    .qual    (ch_en | ch_brk),
    .hit     (hit),
    .hit_idx (hit_idx)
  );

  dbg_seq_next #(.NCH(NCH)) u_next (
    .cur        (cur_q),
    .armed_q    (armed_q),
    .arm_wr     (arm_wr),
    .arm_wdata  (arm_wdata),
    .sw_trig    (sw_trig),
    .trace_mode (trace_mode),
    .hit        (hit),
    .hit_brk    (ch_brk[hit_idx]),
    .tgt_sel    (tgt_sel),
    .nxt        (nxt),
    .nxt_armed  (nxt_armed)
  );

  assign brk_any = |(match & ch_brk);
  assign clr_req = arm_wr & ~arm_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q        <= ST_IDLE;
      armed_q      <= 1'b0;
      trace_trig   <= 1'b0;
      brk_req      <= 1'b0;
      disarm       <= 1'b0;
      session_done <= 1'b0;
    end else begin
      cur_q        <= nxt;
      armed_q      <= nxt_armed;
      trace_trig   <= (nxt == ST_FINAL) && (cur_q != ST_FINAL);
      brk_req      <= armed_q && brk_any;
      disarm       <= armed_q && !nxt_armed;
      session_done <= (cur_q == ST_FINAL) && !clr_req;
    end
  end

  assign state_flags = cur_q;
  assign armed       = armed_q;

endmodule

// File: rtl/dbg_seq_chk.sv
module dbg_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       arm_wr,
  input logic       arm_wdata,
  input logic [2:0] state_flags,
  input logic       armed,
  input logic       trace_trig,
  input logic       brk_req,
  input logic       disarm,
  input logic       session_done
);

  assert_flags_legal_R3: assert property (@(posedge clk) disable iff (rst)
    state_flags <= 3'd4);

  assert_final_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    (state_flags == 3'd4) |=> (state_flags == 3'd0 && !armed));

  assert_done_after_final_R6: assert property (@(posedge clk) disable iff (rst)
    session_done |-> (state_flags == 3'd0 && $past(state_flags) == 3'd4));

  assert_disarm_edge_R6: assert property (@(posedge clk) disable iff (rst)
    disarm |-> (!armed && $past(armed)));

  assert_trig_on_entry_R11: assert property (@(posedge clk) disable iff (rst)
    trace_trig |-> (state_flags == 3'd4 && $past(state_flags) != 3'd4));

  assert_idle_when_disarmed_R10: assert property (@(posedge clk) disable iff (rst)
    !armed |-> state_flags == 3'd0);

  assert_ignore_disarmed_R10: assert property (@(posedge clk) disable iff (rst)
    (!armed && !arm_wr) |=> (!armed && !brk_req && !trace_trig));

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (arm_wr && !arm_wdata) |=> (state_flags == 3'd0 && !armed && !session_done));

endmodule

bind dbg_seq_top dbg_seq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .arm_wr       (arm_wr),
  .arm_wdata    (arm_wdata),
  .state_flags  (state_flags),
  .armed        (armed),
  .trace_trig   (trace_trig),
  .brk_req      (brk_req),
  .disarm       (disarm),
  .session_done (session_done)
);

// File: tb/dbg_seq_top_bench.sv
module dbg_seq_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       arm_wr = 1'b0, arm_wdata = 1'b0, sw_trig = 1'b0;
  logic [1:0] trace_mode = 2'd0;
  logic [3:0] ch_en = '0, ch_brk = '0, match = '0;
  logic [5:0] tgt_sel = '0;
  logic [2:0] state_flags;
  logic       armed, trace_trig, brk_req, disarm, session_done;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_seq_top #(.NCH(NCH)) u_dbg_seq_top (
    .clk(clk), .rst(rst), .arm_wr(arm_wr), .arm_wdata(arm_wdata),
    .sw_trig(sw_trig), .trace_mode(trace_mode), .ch_en(ch_en), .ch_brk(ch_brk),
    .tgt_sel(tgt_sel), .match(match), .state_flags(state_flags), .armed(armed),
    .trace_trig(trace_trig), .brk_req(brk_req), .disarm(disarm),
    .session_done(session_done)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_strobes();
    arm_wr = 0; arm_wdata = 0; sw_trig = 0; match = '0;
  endtask

  task automatic clear_arm();
    arm_wr = 1; arm_wdata = 0;
    tick();
    clear_strobes();
  endtask

  // reach state s (1..3) from idle through channel 0 with field of state 1
  task automatic goto_state(input int s);
    arm_wr = 1; arm_wdata = 1;
    tick();
    clear_strobes();
    if (s > 1) begin
      tgt_sel = {4'b0000, 2'(s)};
      ch_en = 4'b0001; ch_brk = 4'b0000; match = 4'b0001;
      tick();
      clear_strobes();
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    chk("R1", "flags", int'(state_flags), 0);
    chk("R1", "armed", int'(armed), 0);
    chk("R1", "pulses", int'({trace_trig, brk_req, disarm, session_done}), 0);
    rst = 0;
    @(negedge clk);

    // R10: everything ignored while disarmed
    ch_en = 4'hF; ch_brk = 4'hF; match = 4'hF; sw_trig = 1; trace_mode = 2'd1;
    tick();
    clear_strobes();
    chk("R10", "flags disarmed", int'(state_flags), 0);
    chk("R10", "brk disarmed", int'(brk_req), 0);
    chk("R10", "trig disarmed", int'(trace_trig), 0);

    // R2 arm, then R10 re-arm has no effect
    goto_state(1);
    chk("R2", "flags after arm", int'(state_flags), 1);
    chk("R2", "armed after arm", int'(armed), 1);
    arm_wr = 1; arm_wdata = 1;
    tick();
    clear_strobes();
    chk("R10", "rearm flags", int'(state_flags), 1);
    chk("R10", "rearm armed", int'(armed), 1);

    // R9: clear wins over a break match
    ch_en = 4'h1; ch_brk = 4'h1; match = 4'h1; arm_wr = 1; arm_wdata = 0;
    tick();
    clear_strobes();
    chk("R9", "clear flags", int'(state_flags), 0);
    chk("R9", "clear disarm pulse", int'(disarm), 1);
    chk("R9", "clear no trig", int'(trace_trig), 0);

    // R9: clear while in final gives no session_done
    ch_en = 4'h0; ch_brk = 4'h0;
    goto_state(1);
    sw_trig = 1; trace_mode = 2'd1;
    tick();
    clear_strobes();
    chk("R11", "final trig", int'(trace_trig), 1);
    arm_wr = 1; arm_wdata = 0;
    tick();
    clear_strobes();
    chk("R9", "clear in final flags", int'(state_flags), 0);
    chk("R9", "clear in final no done", int'(session_done), 0);
    chk("R6", "clear in final disarm", int'(disarm), 1);

    // R5 software trigger over every mode and state, with a break match (R4, R7)
    for (int s = 1; s <= 3; s++) begin
      for (int m = 0; m < 4; m++) begin
        ch_en = 4'h0; ch_brk = 4'h0;
        goto_state(s);
        chk("R3", "reach state", int'(state_flags), s);
        ch_en = 4'h0; ch_brk = 4'h2; tgt_sel = 6'b111111;
        trace_mode = 2'(m); sw_trig = 1; match = 4'h2;
        tick();
        clear_strobes();
        chk("R7", "brk with sw trig", int'(brk_req), 1);
        if (m == 1 || m == 2) begin
          chk("R5", "sw to final", int'(state_flags), 4);
          chk("R11", "sw trig pulse", int'(trace_trig), 1);
          tick();
          chk("R6", "final exit flags", int'(state_flags), 0);
          chk("R6", "session done", int'(session_done), 1);
          chk("R6", "disarm pulse", int'(disarm), 1);
        end else begin
          chk("R5", "sw to idle", int'(state_flags), 0);
          chk("R5", "sw idle disarm", int'(disarm), 1);
          chk("R5", "sw idle no done", int'(session_done), 0);
          tick();
        end
      end
    end
    trace_mode = 2'd0;

    // R3 R4 R7 R8 R12 exhaustive sweep of match, enable and break masks
    for (int s = 1; s <= 3; s++) begin
      for (int pat = 1; pat < 16; pat++) begin
        for (int en = 0; en < 16; en++) begin
          for (int bk = 0; bk < 16; bk++) begin
            logic [3:0] act;
            logic [1:0] fld;
            int win, exp_st;
            ch_en = 4'h0; ch_brk = 4'h0;
            goto_state(s);
            fld = 2'(pat) ^ 2'(en) ^ 2'(s);
            tgt_sel = {fld, fld, fld};
            ch_en = 4'(en); ch_brk = 4'(bk); match = 4'(pat);
            tick();
            clear_strobes();
            act = 4'(pat) & (4'(en) | 4'(bk));
            win = -1;
            for (int i = 3; i >= 0; i--) if (act[i]) win = i;
            if (win < 0) exp_st = s;
            else if (bk[win]) exp_st = 4;
            else exp_st = (fld == 2'd0) ? 4 : int'(fld);
            chk((win < 0) ? "R12" : (bk[win] ? "R8" : "R4"), "sweep flags",
                int'(state_flags), exp_st);
            chk("R7", "sweep brk", int'(brk_req), int'(|(4'(pat) & 4'(bk))));
            chk("R11", "sweep trig", int'(trace_trig), (exp_st == 4) ? 1 : 0);
            if (exp_st == 4) begin
              tick();
              chk("R8", "final one cycle", int'(state_flags), 0);
              chk("R6", "sweep done", int'(session_done), 1);
              chk("R8", "sweep disarmed", int'(armed), 0);
            end else begin
              chk("R3", "sweep armed", int'(armed), 1);
              clear_arm();
            end
          end
        end
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule